// File: doc/BRIEF.md
# Configuration Item DMA Engine

This block moves the bytes of a configuration item into system memory without the host reading them one at a time. The host places a 16-byte descriptor in memory and writes the descriptor's 64-bit address into the engine's register window. The engine then fetches the descriptor byte by byte over a simple request/acknowledge memory master port. It can select a new item. It then either copies item bytes to the target buffer or steps the item offset forward without writing anything. When it has finished, it writes a status word back into the first four bytes of the descriptor.

The current item key and offset live in a separate item port. The engine requests a select with `sel_valid`/`sel_key` and moves the offset forward with `item_adv`/`item_adv_n`. The item port reports how many bytes of the current item are left (`item_avail`, zero for an invalid or empty item) and the byte at the current offset (`item_data`). Reads of the register window return a fixed 64-bit identification constant, so software can detect that the engine is present.

Top module: `cfg_dma_engine`

## Requirements
- R1: Register writes are accepted only in three forms. A 4-byte write at offset 0 loads the upper address half. A 4-byte write at offset 4 merges the lower half into the stored address and starts a transfer. An 8-byte write at offset 0 loads the whole address and starts a transfer. Writes of any other size or at any other offset have no effect.
- R2: A read of `reg_size` bytes (1, 2, 4 or 8) at `reg_off` returns the bytes at positions reg_off..reg_off+size-1 of the constant 0x51454D5520434647, counting byte 0 as the most significant. The first byte read is the most significant of the result, and the result is right-aligned in `reg_rdata`.
- R3: The descriptor is fetched as 16 byte reads from ascending addresses starting at the descriptor address. Bytes 0-3 hold the control word, bytes 4-7 the length and bytes 8-15 the target address, each most-significant byte first.
- R4: If control bit 3 (value 0x08) is set, the key in control bits 31:16 is sent on `sel_key` with a one-cycle `sel_valid`, before any data access. This selects that item and resets its offset to zero.
- R5: Control bit 1 (read, 0x02) takes priority over bit 2 (skip, 0x04). If neither bit is set, no data is moved and the status is zero. Control bit 0 in the fetched descriptor has no effect.
- R6: A read writes the item bytes, in order, to ascending target addresses and moves the offset forward by one for each byte written.
- R7: Once the item is exhausted or invalid (`item_avail` = 0), a read writes zero bytes for the rest of the length and does not move the offset.
- R8: A skip moves the offset forward by min(remaining length, `item_avail`) in a single step and issues no memory writes. Length beyond the end of the item is consumed without effect.
- R9: At the end, the 32-bit status is written as four byte writes, most significant byte first, to descriptor bytes 0-3. The status is 0 on success and 0x01 if a data write returned `mem_err`. The transfer stops at the first failed write.
- R10: If any descriptor byte read returns `mem_err`, the fetch is abandoned and only status 0x01 is written back. No select and no offset change take place.
- R11: The stored descriptor address is cleared when a transfer starts, so a later lone lower-half write uses zero as its upper half.
- R12: `busy` is high from the cycle after a start until the last status byte is acknowledged. All register writes made while `busy` is high are ignored. While `busy` is low the engine makes no memory request, select or advance.
- R13: A memory request keeps its address, direction and data steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_off | input | 3 | Byte offset of the access within the window |
| reg_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completed request failed |
| sel_valid | output | 1 | Select request to the item port |
| sel_key | output | 16 | Key to select |
| item_avail | input | 32 | Bytes left in the current item (0 if invalid) |
| item_data | input | 8 | Item byte at the current offset |
| item_adv | output | 1 | Advance the item offset |
| item_adv_n | output | 32 | Number of bytes to advance |

## Verification
A table of descriptors covers several cases: a read with a select, a read that runs past the item end, a skip, read and skip both set, neither set, a select of an invalid key, a read with a failing target write, an oversized skip and a zero length. Each case is compared with a model of the item offset and the memory image, so copy, zero fill, skip and priority show up as different target bytes or offsets. Directed tests read the signature at several offsets and sizes, and confirm that malformed writes and writes made while busy start nothing. A failing descriptor fetch followed by a lone lower-half write separates the fetch-abort path from the address-clear behaviour.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned LEN_W      = 32;
  localparam int unsigned KEY_W      = 16;
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned STAT_BYTES = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_BYTES);

  localparam int unsigned BIT_ERR  = 0;
  localparam int unsigned BIT_RD   = 1;
  localparam int unsigned BIT_SKIP = 2;
  localparam int unsigned BIT_SEL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_XFER,
    ST_STATUS
  } dma_state_e;

  typedef struct packed {
    logic [31:0]       ctl;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] tgt;
  } desc_t;
endpackage

// File: rtl/cfg_dma_regwin.sv
module cfg_dma_regwin
  import cfg_dma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h51454D5520434647
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              hi_wr, lo_wr, full_wr;
  logic [3:0]        end_b;
  logic              size_ok;
  logic [63:0]       shifted;

  // signature read path
  always_comb begin
    end_b   = {1'b0, reg_off} + reg_size;
    size_ok = ((reg_size == 4'd1) || (reg_size == 4'd2) ||
               (reg_size == 4'd4) || (reg_size == 4'd8)) && (end_b <= 4'd8);
    shifted = SIGNATURE >> {(4'd8 - end_b), 3'b000};
    for (int b = 0; b < 8; b++) begin
      reg_rdata[b*8 +: 8] = (size_ok && (4'(b) < reg_size)) ? shifted[b*8 +: 8] : 8'h00;
    end
  end

  // write decode
  always_comb begin
    hi_wr   = reg_wr && !busy && (reg_size == 4'd4) && (reg_off == 3'd0);
    lo_wr   = reg_wr && !busy && (reg_size == 4'd4) && (reg_off == 3'd4);
    full_wr = reg_wr && !busy && (reg_size == 4'd8) && (reg_off == 3'd0);
    start   = lo_wr || full_wr;
    start_addr = full_wr ? reg_wdata : (addr_q | {32'h0, reg_wdata[31:0]});
    addr_n = addr_q;
    if (start) begin
      addr_n = '0;
    end else if (hi_wr) begin
      addr_n = {reg_wdata[31:0], 32'h0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_n;
    end
  end
endmodule

// File: rtl/cfg_dma_shift.sv
module cfg_dma_shift #(
  parameter int unsigned NBYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [7:0]            din,
  output logic [NBYTES*8-1:0]   vec
);
  logic [NBYTES*8-1:0] vec_q, vec_n;

  always_comb begin
    vec_n = vec_q;
    if (load) begin
      vec_n = {vec_q[NBYTES*8-9:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else begin
      vec_q <= vec_n;
    end
  end

  assign vec = vec_q;
endmodule

// File: rtl/cfg_dma_ctrl.sv
module cfg_dma_ctrl
  import cfg_dma_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      start_addr,
  input  logic [DESC_BYTES*8-1:0] desc_vec,
  output logic                   shift_load,
  output logic                   busy,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic                   mem_ack,
  input  logic                   mem_err,
  output logic                   sel_valid,
  output logic [KEY_W-1:0]       sel_key,
  input  logic [LEN_W-1:0]       item_avail,
  input  logic [7:0]             item_data,
  output logic                   item_adv,
  output logic [LEN_W-1:0]       item_adv_n
);
  dma_state_e        state_q, state_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] tgt_q, tgt_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              rd_q, rd_n;
  logic              err_q, err_n;
  desc_t             desc;
  logic [LEN_W-1:0]  chunk;
  logic [31:0]       stat_sh;
  logic              unused_ctl;

  assign desc       = desc_t'(desc_vec);
  assign unused_ctl = ^{desc.ctl[15:4], desc.ctl[BIT_ERR]};
  assign chunk      = (rem_q < item_avail) ? rem_q : item_avail;
  assign stat_sh    = {31'h0, err_q} << {idx_q, 3'b000};
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_n    = state_q;
    base_n     = base_q;
    tgt_n      = tgt_q;
    rem_n      = rem_q;
    idx_n      = idx_q;
    rd_n       = rd_q;
    err_n      = err_q;
    shift_load = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = 8'h00;
    sel_valid  = 1'b0;
    sel_key    = desc.ctl[31:16];
    item_adv   = 1'b0;
    item_adv_n = '0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          base_n  = start_addr;
          idx_n   = '0;
          err_n   = 1'b0;
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + ADDR_W'(idx_q);
        if (mem_ack) begin
          if (mem_err) begin
            err_n   = 1'b1;
            idx_n   = '0;
            state_n = ST_STATUS;
          end else begin
            shift_load = 1'b1;
            idx_n      = idx_q + 1'b1;
            if (idx_q == IDX_W'(DESC_BYTES - 1)) begin
              state_n = ST_DECODE;
            end
          end
        end
      end
      ST_DECODE: begin
        sel_valid = desc.ctl[BIT_SEL];
        rd_n      = desc.ctl[BIT_RD];
        rem_n     = (desc.ctl[BIT_RD] || desc.ctl[BIT_SKIP]) ? desc.len : '0;
        tgt_n     = desc.tgt;
        state_n   = ST_XFER;
      end
      ST_XFER: begin
        if (rem_q == '0) begin
          idx_n   = '0;
          state_n = ST_STATUS;
        end else if (rd_q) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = tgt_q;
          mem_wdata = (item_avail != '0) ? item_data : 8'h00;
          if (mem_ack) begin
            if (item_avail != '0) begin
              item_adv   = 1'b1;
              item_adv_n = LEN_W'(1);
            end
            tgt_n = tgt_q + 1'b1;
            rem_n = rem_q - 1'b1;
            if (mem_err) begin
              err_n   = 1'b1;
              idx_n   = '0;
              state_n = ST_STATUS;
            end
          end
        end else if (item_avail == '0) begin
          tgt_n = tgt_q + ADDR_W'(rem_q);
          rem_n = '0;
        end else begin
          item_adv   = 1'b1;
          item_adv_n = chunk;
          tgt_n      = tgt_q + ADDR_W'(chunk);
          rem_n      = rem_q - chunk;
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + ADDR_W'(idx_q);
        mem_wdata = stat_sh[31:24];
        if (mem_ack) begin
          idx_n = idx_q + 1'b1;
          if (idx_q == IDX_W'(STAT_BYTES - 1)) begin
            state_n = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      tgt_q   <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      base_q  <= base_n;
      tgt_q   <= tgt_n;
      rem_q   <= rem_n;
      idx_q   <= idx_n;
      rd_q    <= rd_n;
      err_q   <= err_n;
    end
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h51454D5520434647
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_off,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  output logic        sel_valid,
  output logic [15:0] sel_key,
  input  logic [31:0] item_avail,
  input  logic [7:0]  item_data,
  output logic        item_adv,
  output logic [31:0] item_adv_n
);
  logic                    start;
  logic [ADDR_W-1:0]       start_addr;
  logic                    shift_load;
  logic [DESC_BYTES*8-1:0] desc_vec;

  cfg_dma_regwin #(.SIGNATURE(SIGNATURE)) u_regwin (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .reg_wr     (reg_wr),
    .reg_off    (reg_off),
    .reg_size   (reg_size),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .start      (start),
    .start_addr (start_addr)
  );

  cfg_dma_shift #(.NBYTES(DESC_BYTES)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (shift_load),
    .din   (mem_rdata),
    .vec   (desc_vec)
  );

  cfg_dma_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .desc_vec   (desc_vec),
    .shift_load (shift_load),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .sel_valid  (sel_valid),
    .sel_key    (sel_key),
    .item_avail (item_avail),
    .item_data  (item_data),
    .item_adv   (item_adv),
    .item_adv_n (item_adv_n)
  );
endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk #(
  parameter logic [63:0] SIGNATURE = 64'h51454D5520434647
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_off,
  input logic [3:0]  reg_size,
  input logic [63:0] reg_rdata,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ack,
  input logic        sel_valid,
  input logic [31:0] item_avail,
  input logic        item_adv,
  input logic [31:0] item_adv_n
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !sel_valid && !item_adv));

  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_size == 4'd8 && reg_off == 3'd0) |=> busy);

  assert_adv_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    item_adv |-> (item_adv_n != 32'd0 && item_adv_n <= item_avail));

  assert_sel_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (!mem_req && !item_adv));

  assert_sel_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !sel_valid);

  assert_sig_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_size == 4'd8 && reg_off == 3'd0) |-> (reg_rdata == SIGNATURE));
endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.SIGNATURE(SIGNATURE)) u_chk (.*);

// File: tb/sim_cfg_dma_engine.sv
module sim_cfg_dma_engine;
  localparam int PERIOD = 10;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_off;
  logic [3:0]  reg_size;
  logic [63:0] reg_wdata, reg_rdata;
  logic        busy, mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack, mem_err;
  logic        sel_valid;
  logic [15:0] sel_key;
  logic [31:0] item_avail;
  logic [7:0]  item_data;
  logic        item_adv;
  logic [31:0] item_adv_n;

  int errors = 0;
  int checks = 0;

  cfg_dma_engine u0 (.*);

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // ---------------- item port model ----------------
  logic [15:0] st_key;
  logic [31:0] st_off;

  function automatic logic [31:0] item_len(input logic [15:0] k);
    case (k)
      16'h0001: item_len = 32'd5;
      16'h0002: item_len = 32'd3;
      default:  item_len = 32'd0;
    endcase
  endfunction

  function automatic logic [7:0] item_byte(input logic [15:0] k, input logic [31:0] o);
    item_byte = 8'(k[3:0] * 16) + o[7:0] + 8'd1;
  endfunction

  assign item_avail = (st_off < item_len(st_key)) ? item_len(st_key) - st_off : 32'd0;
  assign item_data  = item_byte(st_key, st_off);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_key <= 16'h0;
      st_off <= 32'h0;
    end else if (sel_valid) begin
      st_key <= sel_key;
      st_off <= 32'h0;
    end else if (item_adv) begin
      st_off <= st_off + item_adv_n;
    end
  end

  // ---------------- memory model ----------------
  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  logic       fail_en;
  logic [7:0] fail_a;
  int         req_count;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req && rst_n) begin
      req_count++;
      mem_ack = 1'b1;
      mem_err = (mem_addr[63:8] != 56'h0) || (mem_we && fail_en && mem_addr[7:0] == fail_a);
      if (!mem_err) begin
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:0]];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_off = 3'd0; reg_size = 4'd0; reg_wdata = '0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic put_desc(input logic [7:0] at, input logic [31:0] ctl, input logic [31:0] len, input logic [7:0] tgt);
    for (int b = 0; b < 4; b++) mem[at + 8'(b)] = ctl[31 - 8*b -: 8];
    for (int b = 0; b < 4; b++) mem[at + 8'(4 + b)] = len[31 - 8*b -: 8];
    for (int b = 0; b < 7; b++) mem[at + 8'(8 + b)] = 8'h00;
    mem[at + 8'd15] = tgt;
  endtask

  // ---------------- vector table ----------------
  // {ctl[31:0], len[15:0], tgt[7:0], fail_en, fail_addr[7:0]}
  localparam int NV = 9;
  localparam logic [64:0] VEC [0:NV-1] = '{
    {32'h0001_000A, 16'd3,  8'h40, 1'b0, 8'h00},  // select key1, read 3      R4 R6
    {32'h0000_0002, 16'd4,  8'h48, 1'b0, 8'h00},  // read past end            R7
    {32'h0001_000C, 16'd2,  8'h00, 1'b0, 8'h00},  // select, skip 2           R8
    {32'h0000_0006, 16'd2,  8'h50, 1'b0, 8'h00},  // read and skip both       R5
    {32'h0002_0009, 16'd7,  8'h58, 1'b0, 8'h00},  // neither bit, err bit in  R5
    {32'h0020_000A, 16'd3,  8'h58, 1'b0, 8'h00},  // invalid key read zeros   R7
    {32'h0001_000A, 16'd5,  8'h60, 1'b1, 8'h62},  // write fault at 0x62      R9
    {32'h0002_000C, 16'd10, 8'h00, 1'b0, 8'h00},  // oversized skip           R8
    {32'h0000_0002, 16'd0,  8'h70, 1'b0, 8'h00}   // zero length              R6
  };

  logic [15:0] ref_key;
  logic [31:0] ref_off;

  task automatic ref_run(input logic [31:0] ctl, input logic [31:0] len, input logic [7:0] tgt,
                         input bit fe, input logic [7:0] fa, output logic [7:0] st);
    logic [31:0] rem;
    bit rd;
    st = 8'h00;
    if (ctl[3]) begin ref_key = ctl[31:16]; ref_off = 0; end
    rd  = ctl[1];
    rem = (ctl[1] || ctl[2]) ? len : 32'd0;
    for (int i = 0; i < int'(rem); i++) begin
      if (rd) begin
        if (fe && (tgt + 8'(i)) == fa) begin
          st = 8'h01;
          if (ref_off < item_len(ref_key)) ref_off++;
          break;
        end
        if (ref_off < item_len(ref_key)) begin
          exp_mem[tgt + 8'(i)] = item_byte(ref_key, ref_off);
          ref_off++;
        end else begin
          exp_mem[tgt + 8'(i)] = 8'h00;
        end
      end else if (ref_off < item_len(ref_key)) begin
        ref_off++;
      end
    end
    exp_mem[0] = 8'h00; exp_mem[1] = 8'h00; exp_mem[2] = 8'h00; exp_mem[3] = st;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] st;
    int mism;
    int rc0;
    logic [15:0] k0;
    logic [31:0] o0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_off = '0; reg_size = '0; reg_wdata = '0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 8'h00;
    fail_en = 1'b0; fail_a = 8'h00; req_count = 0;
    ref_key = 16'h0; ref_off = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state R12
    check(!busy && !mem_req && !sel_valid && !item_adv, "R12 reset idle", {busy, mem_req, sel_valid, item_adv}, 0);

    // signature reads R2
    reg_off = 3'd0; reg_size = 4'd8; #1;
    check(reg_rdata == 64'h51454D5520434647, "R2 sig 8@0", reg_rdata, 64'h51454D5520434647);
    reg_off = 3'd4; reg_size = 4'd4; #1;
    check(reg_rdata == 64'h20434647, "R2 sig 4@4", reg_rdata, 64'h20434647);
    reg_off = 3'd2; reg_size = 4'd2; #1;
    check(reg_rdata == 64'h4D55, "R2 sig 2@2", reg_rdata, 64'h4D55);
    reg_off = 3'd7; reg_size = 4'd1; #1;
    check(reg_rdata == 64'h47, "R2 sig 1@7", reg_rdata, 64'h47);
    reg_off = 3'd0; reg_size = 4'd1; #1;
    check(reg_rdata == 64'h51, "R2 sig 1@0", reg_rdata, 64'h51);
    reg_off = 3'd0; reg_size = 4'd0;

    // malformed writes ignored R1
    rc0 = req_count;
    reg_write(3'd0, 4'd2, 64'h0);
    reg_write(3'd2, 4'd4, 64'h0);
    reg_write(3'd4, 4'd8, 64'h0);
    reg_write(3'd4, 4'd1, 64'h0);
    repeat (4) @(negedge clk);
    check(!busy && req_count == rc0, "R1 ignored writes", req_count - rc0, 0);

    // vector table R3..R9
    for (int v = 0; v < NV; v++) begin
      logic [31:0] c; logic [31:0] l; logic [7:0] t; bit fe; logic [7:0] fa;
      c = VEC[v][64:33]; l = {16'h0, VEC[v][32:17]}; t = VEC[v][16:9]; fe = VEC[v][8]; fa = VEC[v][7:0];
      put_desc(8'h00, c, l, t);
      for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
      fail_en = fe; fail_a = fa;
      ref_run(c, l, t, fe, fa, st);
      if (v % 2 == 0) reg_write(3'd0, 4'd8, 64'h0);
      else begin
        reg_write(3'd0, 4'd4, 64'h0);
        reg_write(3'd4, 4'd4, 64'h0);
      end
      wait_idle();
      fail_en = 1'b0;
      check(mem[3] == st && mem[0] == 8'h00, $sformatf("R9 status vec%0d", v), {mem[0], mem[3]}, {8'h00, st});
      mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
      check(mism == 0, $sformatf("R3 R5 R6 R7 R8 memory image vec%0d", v), mism, 0);
      check(st_off == ref_off && st_key == ref_key, $sformatf("R4 R6 R8 item key/offset vec%0d", v),
            {st_key, st_off}, {ref_key, ref_off});
    end

    // busy ignores new triggers R12
    put_desc(8'h00, 32'h0001_000A, 32'd8, 8'hA0);
    for (int i = 0; i < 4; i++) mem[8'h20 + 8'(i)] = 8'hAA;
    put_desc(8'h30, 32'h0002_000A, 32'd2, 8'hC0);
    for (int i = 0; i < 4; i++) mem[8'h30 + 8'(i)] = 8'hAA;
    reg_write(3'd0, 4'd8, 64'h0);
    check(busy == 1'b1, "R12 busy after start", busy, 1);
    repeat (3) @(negedge clk);
    reg_write(3'd0, 4'd8, 64'h30);
    wait_idle();
    repeat (20) @(negedge clk);
    check(!busy && mem[8'h33] == 8'hAA && mem[3] == 8'h00, "R12 trigger while busy ignored",
          {busy, mem[8'h33]}, {1'b0, 8'hAA});

    // fetch failure R10
    k0 = st_key; o0 = st_off;
    reg_write(3'd0, 4'd4, 64'h1);
    reg_write(3'd4, 4'd4, 64'h30);
    wait_idle();
    check(st_key == k0 && st_off == o0 && mem[8'h33] == 8'hAA, "R10 fetch fault no transfer",
          {st_key, st_off}, {k0, o0});

    // address cleared at start R11
    put_desc(8'h80, 32'h0002_000A, 32'd2, 8'h90);
    reg_write(3'd4, 4'd4, 64'h80);
    wait_idle();
    check(mem[8'h83] == 8'h00 && mem[8'h90] == item_byte(16'h2, 0) && mem[8'h91] == item_byte(16'h2, 1),
          "R11 upper half cleared", {mem[8'h83], mem[8'h90]}, {8'h00, item_byte(16'h2, 0)});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule